// File: doc/BRIEF.md
# Multichannel Audio Sample FIFO

This block is a one-direction sample buffer placed between a processor-facing data port and a serial audio engine. One side pushes 24-bit samples carried in the low bits of a 32-bit word, and the other side pops them in the same order. The number of frames the buffer may hold depends on two configuration inputs: a 3-bit size code that picks the RAM word count, and the channel count of the stream. Occupancy is reported in whole frames, not in words.

A control word carries a one-shot clear of the buffer contents and an enable for the half-level interrupt request. A status word carries the frame level and two sticky error flags, one for pushing into a full buffer and one for popping from an empty one. A parameter selects the transmit or the receive flavour. The two flavours differ only in the direction of the half-level test.

Top module: `audio_sample_fifo`

## Requirements
- R1: After reset the status word, control word, half-level request and pop data all read zero.
- R2: Words pop in the order they were pushed. Push bits [23:0] are stored and bits [31:24] are ignored. Pop bits [31:24] always read zero, so a 16-bit sample placed at [23:8] comes back at [23:8].
- R3: The frame capacity is (256 << code) halved once for each doubling of one needed to reach the channel count. The channel count is cfg_chans + 1. For 256 words this gives 256, 128, 64, 64, 32, 32, 32 and 32 frames for 1 to 8 channels. The word capacity is the frame capacity times the channel count.
- R4: Status bits [16:8] report floor(stored words / channels), saturated at 511.
- R5: A push while the stored words equal the word capacity is dropped and sets status bit 4 (overrun).
- R6: A pop while empty returns zero and sets status bit 0 (underrun).
- R7: The error flags stay set until a status write carries 0 in that flag's position. A write of 1 in that position keeps the flag. A new error in the same cycle as the write wins.
- R8: A control write with bit 0 set makes control bit 0 read 1 for one cycle. The buffer is then empty on the next cycle and bit 0 reads 0 again. The clear leaves bit 20 unchanged.
- R9: Control bit 20 is the half-level enable and reads back as written. The request is low whenever the enable is 0.
- R10: In the transmit flavour (TX_SIDE=1), the enabled request is high when the stored frames are at or below half the frame capacity.
- R11: In the receive flavour (TX_SIDE=0), the enabled request is high when the stored frames are at or above half the frame capacity.
- R12: A size code above MAX_SIZE_CODE behaves as MAX_SIZE_CODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size | input | 3 | RAM size code (256 << code words) |
| cfg_chans | input | 3 | Channel count minus one |
| push_en | input | 1 | Push one sample word this cycle |
| push_data | input | 32 | Sample word, valid bits [23:0] |
| pop_en | input | 1 | Pop one sample word this cycle |
| pop_data | output | 32 | Head sample word, zero when empty |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control write data (bit 0 clear, bit 20 enable) |
| ctl_rdata | output | 32 | Control word readback |
| st_we | input | 1 | Status word write strobe |
| st_wdata | input | 32 | Status write data (0 in bit 4/0 clears flag) |
| st_rdata | output | 32 | Level [16:8], overrun [4], underrun [0] |
| half_irq | output | 1 | Half-level interrupt request |

## Verification
The buffer is tried with two channels at the smallest size, which separates word count from frame count through a floor division. Three channels exercise the rounded-up capacity, where 192 words fill the buffer rather than 256. Filling one channel at an oversized code shows the clamp and the 511 saturation together. Eight channels show the smallest frame capacity. Popping the three-channel buffer across exactly half capacity tells the transmit test from the receive test at the equality point and one frame below it. A partly written status word tells per-flag clearing from a blanket clear.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    localparam int BASE_WORDS = 256;
    localparam int SMP_W      = 24;
    localparam int LVL_W      = 9;

    // control and status bit positions
    localparam int CT_CLR   = 0;
    localparam int CT_IE    = 20;
    localparam int ST_UNDER = 0;
    localparam int ST_OVER  = 4;
    localparam int ST_LVL   = 8;

    typedef struct packed {
        logic over;
        logic under;
    } err_t;

    typedef struct packed {
        logic clr_pend;
        logic irq_en;
    } ctl_t;

    // halvings needed so that 2**n covers the channel count (code = count-1)
    function automatic logic [1:0] chan_shift(input logic [2:0] code);
        logic [1:0] s;
        if (code == 3'd0)      s = 2'd0;
        else if (code == 3'd1) s = 2'd1;
        else if (code <= 3'd3) s = 2'd2;
        else                   s = 2'd3;
        return s;
    endfunction

endpackage

// File: rtl/afifo_geom.sv
module afifo_geom
    import afifo_pkg::*;
#(
    parameter int MAX_SIZE_CODE = 1,
    parameter int CNT_W         = 10
) (
    input  logic [2:0]       cfg_size,
    input  logic [2:0]       cfg_chans,
    output logic [CNT_W-1:0] cap_frames,
    output logic [CNT_W-1:0] cap_words,
    output logic [CNT_W-1:0] half_frames
);
    localparam logic [2:0] MAXC = 3'(MAX_SIZE_CODE);

    logic [2:0]       eff_size;
    logic [CNT_W-1:0] ram_words;
    logic [CNT_W-1:0] chans;

    always_comb begin
        eff_size    = (cfg_size > MAXC) ? MAXC : cfg_size;
        ram_words   = CNT_W'(BASE_WORDS) << eff_size;
        cap_frames  = ram_words >> chan_shift(cfg_chans);
        chans       = CNT_W'(cfg_chans) + CNT_W'(1);
        cap_words   = cap_frames * chans;
        half_frames = cap_frames >> 1;
    end

endmodule

// File: rtl/afifo_store.sv
module afifo_store
    import afifo_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int CNT_W  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push_req,
    input  logic [SMP_W-1:0] push_word,
    input  logic             pop_req,
    input  logic [CNT_W-1:0] cap_words,
    output logic [SMP_W-1:0] pop_word,
    output logic [CNT_W-1:0] word_cnt,
    output logic             push_drop,
    output logic             pop_miss
);
    localparam int RAM_WORDS = 1 << ADDR_W;

    logic [SMP_W-1:0]  mem [RAM_WORDS];
    logic [ADDR_W-1:0] wptr, rptr;
    logic              full, empty, push_ok, pop_ok;

    always_comb begin
        full      = (word_cnt >= cap_words);
        empty     = (word_cnt == '0);
        push_ok   = push_req & ~full  & ~clr;
        pop_ok    = pop_req  & ~empty & ~clr;
        push_drop = push_req & full   & ~clr;
        pop_miss  = pop_req  & empty  & ~clr;
        pop_word  = empty ? '0 : mem[rptr];
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr     <= '0;
            rptr     <= '0;
            word_cnt <= '0;
        end else begin
            if (push_ok) wptr <= wptr + ADDR_W'(1);
            if (pop_ok)  rptr <= rptr + ADDR_W'(1);
            word_cnt <= word_cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

endmodule

// File: rtl/afifo_level.sv
module afifo_level
    import afifo_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0] word_cnt,
    input  logic [2:0]       cfg_chans,
    output logic [CNT_W-1:0] frames,
    output logic [LVL_W-1:0] lvl_field
);
    logic [4:0] den;
    logic [4:0] rem;

    // restoring division by a 1..8 divisor, one quotient bit per step
    always_comb begin
        den    = {2'b00, cfg_chans} + 5'd1;
        rem    = '0;
        frames = '0;
        for (int i = CNT_W - 1; i >= 0; i--) begin
            rem = {rem[3:0], word_cnt[i]};
            if (rem >= den) begin
                rem       = rem - den;
                frames[i] = 1'b1;
            end
        end
        lvl_field = (frames > CNT_W'((1 << LVL_W) - 1)) ? '1 : LVL_W'(frames);
    end

endmodule

// File: rtl/afifo_regs.sv
module afifo_regs
    import afifo_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter bit TX_SIDE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic             ctl_clr_bit,
    input  logic             ctl_ie_bit,
    input  logic             st_we,
    input  logic             st_over_bit,
    input  logic             st_under_bit,
    input  logic             push_drop,
    input  logic             pop_miss,
    input  logic [CNT_W-1:0] frames,
    input  logic [CNT_W-1:0] half_frames,
    input  logic [LVL_W-1:0] lvl_field,
    output logic             clr_pend,
    output logic [31:0]      ctl_rdata,
    output logic [31:0]      st_rdata,
    output logic             half_irq
);
    ctl_t ctl_q;
    err_t err_q;
    logic lvl_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            err_q <= '0;
        end else begin
            ctl_q.clr_pend <= ctl_we & ctl_clr_bit;
            if (ctl_we) ctl_q.irq_en <= ctl_ie_bit;
            err_q.over  <= push_drop | (err_q.over  & ~(st_we & ~st_over_bit));
            err_q.under <= pop_miss  | (err_q.under & ~(st_we & ~st_under_bit));
        end
    end

    generate
        if (TX_SIDE) begin : g_tx
            assign lvl_hit = (frames <= half_frames);
        end else begin : g_rx
            assign lvl_hit = (frames >= half_frames);
        end
    endgenerate

    always_comb begin
        clr_pend          = ctl_q.clr_pend;
        half_irq          = ctl_q.irq_en & lvl_hit;
        ctl_rdata         = '0;
        ctl_rdata[CT_CLR] = ctl_q.clr_pend;
        ctl_rdata[CT_IE]  = ctl_q.irq_en;
        st_rdata                     = '0;
        st_rdata[ST_LVL +: LVL_W]    = lvl_field;
        st_rdata[ST_OVER]            = err_q.over;
        st_rdata[ST_UNDER]           = err_q.under;
    end

endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
    import afifo_pkg::*;
#(
    parameter int MAX_SIZE_CODE = 1,
    parameter bit TX_SIDE       = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  cfg_size,
    input  logic [2:0]  cfg_chans,
    input  logic        push_en,
    input  logic [31:0] push_data,
    input  logic        pop_en,
    output logic [31:0] pop_data,
    input  logic        ctl_we,
    input  logic [31:0] ctl_wdata,
    output logic [31:0] ctl_rdata,
    input  logic        st_we,
    input  logic [31:0] st_wdata,
    output logic [31:0] st_rdata,
    output logic        half_irq
);
    localparam int ADDR_W = $clog2(BASE_WORDS) + MAX_SIZE_CODE;
    localparam int CNT_W  = ADDR_W + 1;

    logic [CNT_W-1:0] cap_frames, cap_words, half_frames, word_cnt, frames;
    logic [LVL_W-1:0] lvl_field;
    logic [SMP_W-1:0] pop_word;
    logic             clr_pend, push_drop, pop_miss;
    logic             unused_bits;

    assign unused_bits = ^{ctl_wdata[31:21], ctl_wdata[19:1], st_wdata[31:5],
                           st_wdata[3:1], push_data[31:24], cap_frames};

    afifo_geom #(.MAX_SIZE_CODE(MAX_SIZE_CODE), .CNT_W(CNT_W)) u_geom (
        .cfg_size    (cfg_size),
        .cfg_chans   (cfg_chans),
        .cap_frames  (cap_frames),
        .cap_words   (cap_words),
        .half_frames (half_frames)
    );

    afifo_store #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr_pend),
        .push_req  (push_en),
        .push_word (push_data[SMP_W-1:0]),
        .pop_req   (pop_en),
        .cap_words (cap_words),
        .pop_word  (pop_word),
        .word_cnt  (word_cnt),
        .push_drop (push_drop),
        .pop_miss  (pop_miss)
    );

    afifo_level #(.CNT_W(CNT_W)) u_level (
        .word_cnt  (word_cnt),
        .cfg_chans (cfg_chans),
        .frames    (frames),
        .lvl_field (lvl_field)
    );

    afifo_regs #(.CNT_W(CNT_W), .TX_SIDE(TX_SIDE)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .ctl_we       (ctl_we),
        .ctl_clr_bit  (ctl_wdata[CT_CLR]),
        .ctl_ie_bit   (ctl_wdata[CT_IE]),
        .st_we        (st_we),
        .st_over_bit  (st_wdata[ST_OVER]),
        .st_under_bit (st_wdata[ST_UNDER]),
        .push_drop    (push_drop),
        .pop_miss     (pop_miss),
        .frames       (frames),
        .half_frames  (half_frames),
        .lvl_field    (lvl_field),
        .clr_pend     (clr_pend),
        .ctl_rdata    (ctl_rdata),
        .st_rdata     (st_rdata),
        .half_irq     (half_irq)
    );

    assign pop_data = {{(32 - SMP_W){1'b0}}, pop_word};

endmodule

// File: rtl/afifo_checker.sv
module afifo_checker #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             push_en,
    input logic             pop_en,
    input logic             ctl_we,
    input logic [31:0]      ctl_wdata,
    input logic             st_we,
    input logic [31:0]      ctl_rdata,
    input logic [31:0]      st_rdata,
    input logic [31:0]      pop_data,
    input logic             half_irq,
    input logic             clr_pend,
    input logic [CNT_W-1:0] word_cnt,
    input logic [CNT_W-1:0] cap_words
);
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        word_cnt <= cap_words);

    a_r5_drop_sets_over: assert property (@(posedge clk) disable iff (rst)
        (push_en && word_cnt >= cap_words && !clr_pend) |=> st_rdata[4]);

    a_r6_empty_pop_zero: assert property (@(posedge clk) disable iff (rst)
        (pop_en && word_cnt == '0) |-> pop_data == 32'd0);

    a_r6_miss_sets_under: assert property (@(posedge clk) disable iff (rst)
        (pop_en && word_cnt == '0 && !clr_pend) |=> st_rdata[0]);

    a_r7_over_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_rdata[4] && !st_we) |=> st_rdata[4]);

    a_r8_clear_request: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl_wdata[0]) |=> clr_pend);

    a_r8_clear_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (clr_pend && !(ctl_we && ctl_wdata[0])) |=> (word_cnt == '0 && !clr_pend));

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        half_irq |-> ctl_rdata[20]);

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        pop_data[31:24] == 8'd0);

endmodule

bind audio_sample_fifo afifo_checker #(.CNT_W(CNT_W)) u_afifo_chk (
    .clk       (clk),
    .rst       (rst),
    .push_en   (push_en),
    .pop_en    (pop_en),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .st_we     (st_we),
    .ctl_rdata (ctl_rdata),
    .st_rdata  (st_rdata),
    .pop_data  (pop_data),
    .half_irq  (half_irq),
    .clr_pend  (clr_pend),
    .word_cnt  (word_cnt),
    .cap_words (cap_words)
);

// File: tb/test_audio_sample_fifo.sv
module test_audio_sample_fifo;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_size = 3'd0;
    logic [2:0]  cfg_chans = 3'd0;
    logic        push_en = 1'b0;
    logic [31:0] push_data = '0;
    logic        pop_en = 1'b0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        st_we = 1'b0;
    logic [31:0] st_wdata = '0;
    logic [31:0] pop_data, ctl_rdata, st_rdata;
    logic [31:0] rx_pop_data, rx_ctl_rdata, rx_st_rdata;
    logic        half_irq, rx_half_irq;

    int nchk = 0;
    int nerr = 0;
    logic [31:0] sb_q[$];

    always #4 clk = ~clk;

    audio_sample_fifo #(.MAX_SIZE_CODE(1), .TX_SIDE(1'b1)) i_audio_sample_fifo (
        .clk(clk), .rst(rst), .cfg_size(cfg_size), .cfg_chans(cfg_chans),
        .push_en(push_en), .push_data(push_data), .pop_en(pop_en), .pop_data(pop_data),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .st_we(st_we), .st_wdata(st_wdata), .st_rdata(st_rdata), .half_irq(half_irq)
    );

    audio_sample_fifo #(.MAX_SIZE_CODE(1), .TX_SIDE(1'b0)) i_audio_sample_fifo_rx (
        .clk(clk), .rst(rst), .cfg_size(cfg_size), .cfg_chans(cfg_chans),
        .push_en(push_en), .push_data(push_data), .pop_en(pop_en), .pop_data(rx_pop_data),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(rx_ctl_rdata),
        .st_we(st_we), .st_wdata(st_wdata), .st_rdata(rx_st_rdata), .half_irq(rx_half_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected word capacity, computed from R3 and R12
    function automatic int cap_words_of(input int size, input int chcode);
        int eff, ch, capf, sh;
        eff = (size > 1) ? 1 : size;
        ch = chcode + 1;
        sh = 0;
        while ((1 << sh) < ch) sh++;
        capf = (256 << eff) >> sh;
        return capf * ch;
    endfunction

    task automatic idle();
        @(negedge clk);
        push_en = 1'b0; pop_en = 1'b0; ctl_we = 1'b0; st_we = 1'b0;
        #1;
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk);
        push_en = 1'b1; pop_en = 1'b0; push_data = d;
        if (sb_q.size() < cap_words_of(int'(cfg_size), int'(cfg_chans)))
            sb_q.push_back({8'd0, d[23:0]});
    endtask

    task automatic pop();
        @(negedge clk);
        push_en = 1'b0; pop_en = 1'b1;
    endtask

    task automatic ctl_write(input logic [31:0] d);
        @(negedge clk);
        push_en = 1'b0; pop_en = 1'b0; ctl_we = 1'b1; ctl_wdata = d;
    endtask

    task automatic st_write(input logic [31:0] d);
        @(negedge clk);
        push_en = 1'b0; pop_en = 1'b0; st_we = 1'b1; st_wdata = d;
    endtask

    task automatic clear_all();
        ctl_write(32'h0010_0001);
        idle();
        idle();
        sb_q.delete();
        st_write(32'h0);
        idle();
    endtask

    // scoreboard monitor: compares each popped word against the queue head
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (pop_en && !rst) begin
                if (sb_q.size() > 0) chk("R2 pop order", pop_data, sb_q.pop_front());
                else                 chk("R6 empty pop zero", pop_data, 32'd0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 status", st_rdata, 32'd0);
        chk("R1 control", ctl_rdata, 32'd0);
        chk("R1 irq", {31'd0, half_irq}, 32'd0);
        chk("R1 pop data", pop_data, 32'd0);

        // two channels: level is a floor division (R4), order (R2)
        cfg_size = 3'd0; cfg_chans = 3'd1;
        for (int i = 0; i < 5; i++) push(32'h0000_1100 + 32'(i));
        idle();
        chk("R4 level 5 words 2ch", 32'(st_rdata[16:8]), 32'd2);
        for (int i = 0; i < 5; i++) pop();
        idle();
        chk("R4 level after drain", 32'(st_rdata[16:8]), 32'd0);
        chk("R9 irq off without enable", {31'd0, half_irq}, 32'd0);

        // three channels: capacity 64 frames = 192 words (R3), overrun (R5)
        cfg_chans = 3'd2;
        for (int i = 0; i < 200; i++) push(32'hFF00_0000 | 32'(i * 7));
        idle();
        chk("R3 full level 3ch", 32'(st_rdata[16:8]), 32'd64);
        chk("R5 overrun set", 32'(st_rdata[4]), 32'd1);
        chk("R6 no underrun yet", 32'(st_rdata[0]), 32'd0);
        ctl_write(32'h0010_0000);
        idle();
        chk("R9 enable readback", ctl_rdata, 32'h0010_0000);
        chk("R10 tx irq full", {31'd0, half_irq}, 32'd0);
        chk("R11 rx irq full", {31'd0, rx_half_irq}, 32'd1);
        for (int i = 0; i < 96; i++) pop();
        idle();
        chk("R4 level at half", 32'(st_rdata[16:8]), 32'd32);
        chk("R10 tx irq at half", {31'd0, half_irq}, 32'd1);
        chk("R11 rx irq at half", {31'd0, rx_half_irq}, 32'd1);
        for (int i = 0; i < 3; i++) pop();
        idle();
        chk("R10 tx irq below half", {31'd0, half_irq}, 32'd1);
        chk("R11 rx irq below half", {31'd0, rx_half_irq}, 32'd0);
        for (int i = 0; i < 94; i++) pop();
        idle();
        chk("R6 underrun set", 32'(st_rdata[0]), 32'd1);
        chk("R7 overrun still set", 32'(st_rdata[4]), 32'd1);

        // R7 per-flag clearing
        st_write(32'h0000_0010);
        idle();
        chk("R7 overrun kept by 1", 32'(st_rdata[4]), 32'd1);
        chk("R7 underrun cleared by 0", 32'(st_rdata[0]), 32'd0);
        st_write(32'h0);
        idle();
        chk("R7 both cleared", st_rdata & 32'h11, 32'd0);

        // R8 one-shot clear
        cfg_chans = 3'd1;
        for (int i = 0; i < 10; i++) push(32'h0000_2200 + 32'(i));
        ctl_write(32'h0010_0001);
        idle();
        chk("R8 clear bit visible", 32'(ctl_rdata[0]), 32'd1);
        chk("R8 level before clear", 32'(st_rdata[16:8]), 32'd5);
        idle();
        sb_q.delete();
        chk("R8 clear bit self-clears", 32'(ctl_rdata[0]), 32'd0);
        chk("R8 emptied", 32'(st_rdata[16:8]), 32'd0);
        chk("R8 enable kept", 32'(ctl_rdata[20]), 32'd1);
        chk("R8 pop data empty", pop_data, 32'd0);

        // R12 clamp, R4 saturation with one channel
        cfg_size = 3'd7; cfg_chans = 3'd0;
        for (int i = 0; i < 520; i++) push(32'(i));
        idle();
        chk("R12 clamped capacity level saturates R4", 32'(st_rdata[16:8]), 32'd511);
        chk("R5 overrun at 512 words", 32'(st_rdata[4]), 32'd1);
        chk("R10 tx irq high level", {31'd0, half_irq}, 32'd0);
        chk("R11 rx irq high level", {31'd0, rx_half_irq}, 32'd1);
        pop();
        idle();
        chk("R4 level 511 words", 32'(st_rdata[16:8]), 32'd511);
        clear_all();

        // one channel, smallest size: 256 frames (R3)
        cfg_size = 3'd0;
        for (int i = 0; i < 257; i++) push(32'h0001_0000 + 32'(i));
        idle();
        chk("R3 1ch capacity", 32'(st_rdata[16:8]), 32'd256);
        chk("R5 overrun 1ch", 32'(st_rdata[4]), 32'd1);
        clear_all();
        chk("R10 tx irq empty", {31'd0, half_irq}, 32'd1);
        chk("R11 rx irq empty", {31'd0, rx_half_irq}, 32'd0);

        // eight channels: 32 frames = 256 words (R3)
        cfg_chans = 3'd7;
        for (int i = 0; i < 17; i++) push(32'(i));
        idle();
        chk("R4 level 17 words 8ch", 32'(st_rdata[16:8]), 32'd2);
        chk("R5 no overrun 8ch", 32'(st_rdata[4]), 32'd0);
        for (int i = 17; i < 257; i++) push(32'(i));
        idle();
        chk("R3 8ch capacity", 32'(st_rdata[16:8]), 32'd32);
        chk("R5 overrun 8ch", 32'(st_rdata[4]), 32'd1);
        clear_all();

        // R2 justification: 16-bit sample at [23:8], upper byte ignored
        cfg_chans = 3'd0;
        push(32'hAB12_3400);
        idle();
        chk("R2 head word", pop_data, 32'h0012_3400);
        pop();
        idle();
        chk("R6 no underrun on data", 32'(st_rdata[0]), 32'd0);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule